// File: doc/BRIEF.md
# Block Defect Map Merger

This block gathers pass and fail results for an N-by-N array of reconfigurable blocks. The results arrive from three kinds of test group, and the block turns them into one status per block. For each test-group kind it keeps its own partial map. A block counts as good in a partial map only after at least one pass has been recorded for it and no fail has ever been recorded for it.

A one-cycle start pulse begins a merge. The merge visits every block in row-major order, one block per clock. For each block it records a 2-bit grade (defective, partially recovered or fully recovered) and a retest-candidate flag. The candidate flag is derived from the four orthogonal neighbours and from which test-group kinds those neighbours failed. While the merge walk runs, busy is high and result writes are refused. Done pulses once when the walk ends. The read port returns the grade and flag that the last merge left for any block.

Top module: `defect_map_merge`

## Requirements
- R1: After reset, every block reads back grade 00 with the candidate flag clear, and busy and done are low.
- R2: Map select 0 is the diagonal test-group kind, 1 the east kind and 2 the south kind; select 3 is ignored. A block is good in a map only if at least one pass and no fail have been written for it there since reset, so a fail is permanent.
- R3: A merge grades a block 10 (fully recovered) exactly when it is good in all three maps.
- R4: A merge grades a block 01 (partially recovered) when it is good in one or two maps, and 00 (defective) when it is good in none; code 11 never appears.
- R5: A block that is not fully recovered is flagged as a retest candidate when any of its north, south, east or west neighbours is fully recovered.
- R6: A block that is not fully recovered is also flagged when an east or west neighbour is partially recovered and good in map 1, or a north or south neighbour is partially recovered and good in map 2. A fully recovered block is never flagged.
- R7: A start seen while idle makes busy high for exactly N*N cycles, beginning the next cycle, with blocks visited in row-major order one per clock. Done is high for one cycle, in the first cycle after busy falls.
- R8: A result write presented while busy is high has no effect on any later merge result.
- R9: A start seen while busy is high is ignored and neither lengthens nor restarts the walk.
- R10: The read port shows the grade and flag from the most recent merge; writes made after that merge do not change what is read until the next merge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Result write strobe |
| wr_idx | input | IW | Block index, row*N+col |
| wr_map | input | 2 | Partial map select |
| wr_pass | input | 1 | 1 = configuration passed, 0 = failed |
| start | input | 1 | Merge start pulse |
| busy | output | 1 | Merge walk in progress; writes refused |
| done | output | 1 | One-cycle merge completion pulse |
| rd_idx | input | IW | Block index to read |
| rd_status | output | 2 | Grade of the block from the last merge |
| rd_cand | output | 1 | Retest-candidate flag from the last merge |

## Verification
The assertions assume that start and wr_en are driven as clean levels from reset onward and that the indices stay below N*N. Under those conditions the merge walk and the frozen maps can be checked cycle by cycle. The bench changes inputs only on falling edges, addresses only blocks inside the array, and drives a write or a second start during a walk only to show that the block refuses it. A seeded generator scatters passes and fails over the three maps so that every grade and both neighbour rules appear.

// File: rtl/dmm_pkg.sv
package dmm_pkg;
  localparam int NMAP = 3;
  localparam logic [1:0] ST_DEF  = 2'b00;
  localparam logic [1:0] ST_PART = 2'b01;
  localparam logic [1:0] ST_FULL = 2'b10;

  // grade from the three per-map good bits
  function automatic logic [1:0] grade(input logic [NMAP-1:0] g);
    if (&g)      return ST_FULL;
    else if (|g) return ST_PART;
    else         return ST_DEF;
  endfunction

  // does a neighbour with good bits g make this block worth retesting;
  // horiz selects the east-kind map, otherwise the south-kind map
  function automatic logic link_ok(input logic [NMAP-1:0] g, input logic horiz);
    logic [1:0] s;
    s = grade(g);
    if (s == ST_FULL)      return 1'b1;
    else if (s == ST_PART) return horiz ? g[1] : g[2];
    else                   return 1'b0;
  endfunction
endpackage

// File: rtl/dmm_map_store.sv
module dmm_map_store
  import dmm_pkg::*;
#(
  parameter int NB = 16,
  parameter int IW = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [IW-1:0]              idx,
  input  logic [1:0]                 map,
  input  logic                       pass,
  output logic [NMAP-1:0][NB-1:0]    good
);
  logic [NMAP-1:0][NB-1:0] seen_q, fail_q;

  for (genvar m = 0; m < NMAP; m++) begin : g_map
    logic hit;
    assign hit = we && (map == 2'(m)) && (int'(idx) < NB);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        seen_q[m] <= '0;
        fail_q[m] <= '0;
      end else if (hit) begin
        if (pass) seen_q[m][idx] <= 1'b1;
        else      fail_q[m][idx] <= 1'b1;
      end
    end
    assign good[m] = seen_q[m] & ~fail_q[m];
  end

  // R2: a recorded fail never clears
  a_r2_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_q & $past(fail_q)) == $past(fail_q));
endmodule

// File: rtl/dmm_classify.sv
module dmm_classify
  import dmm_pkg::*;
#(
  parameter int N  = 4,
  parameter int NB = 16,
  parameter int IW = 4
) (
  input  logic [NMAP-1:0][NB-1:0] good,
  input  logic [IW-1:0]           idx,
  output logic [1:0]              status,
  output logic                    cand
);
  function automatic logic [NMAP-1:0] bits_at(input logic [NMAP-1:0][NB-1:0] gv,
                                              input int j);
    logic [NMAP-1:0] r;
    for (int m = 0; m < NMAP; m++) r[m] = gv[m][j];
    return r;
  endfunction

  int row, col, self;

  always_comb begin
    self   = int'(idx);
    row    = self / N;
    col    = self % N;
    status = grade(bits_at(good, self));
    cand   = 1'b0;
    if (status != ST_FULL) begin
      if (col > 0)     cand = cand | link_ok(bits_at(good, self - 1), 1'b1);
      if (col < N - 1) cand = cand | link_ok(bits_at(good, self + 1), 1'b1);
      if (row > 0)     cand = cand | link_ok(bits_at(good, self - N), 1'b0);
      if (row < N - 1) cand = cand | link_ok(bits_at(good, self + N), 1'b0);
    end
  end
endmodule

// File: rtl/dmm_walker.sv
module dmm_walker #(
  parameter int NB = 16,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output logic [IW-1:0] idx
);
  localparam logic [IW-1:0] LAST = IW'(NB - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      idx  <= '0;
    end else begin
      done <= 1'b0;
      if (!busy && start) begin
        busy <= 1'b1;
        idx  <= '0;
      end else if (busy) begin
        if (idx == LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
        idx <= idx + 1'b1;
      end
    end
  end

  // R7: row-major walk, one block per clock
  a_r7_walk_step: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> idx == $past(idx) + 1'b1);
  // R7: walk starts at block 0
  a_r7_walk_origin: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> idx == '0);
  // R7: done follows the last visited block
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy) && $past(idx) == LAST));
endmodule

// File: rtl/defect_map_merge.sv
module defect_map_merge
  import dmm_pkg::*;
#(
  parameter  int N  = 4,
  localparam int NB = N * N,
  localparam int IW = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [1:0]    wr_map,
  input  logic          wr_pass,
  input  logic          start,
  output logic          busy,
  output logic          done,
  input  logic [IW-1:0] rd_idx,
  output logic [1:0]    rd_status,
  output logic          rd_cand
);
  logic [NMAP-1:0][NB-1:0] good;
  logic                    wr_accept;
  logic [IW-1:0]           walk_idx;
  logic [1:0]              status_w;
  logic                    cand_w;
  logic                    st_we;
  logic [1:0]              status_q [NB];
  logic [NB-1:0]           cand_q;

  assign wr_accept = wr_en && !busy;

  dmm_map_store #(.NB(NB), .IW(IW)) u_store (
    .clk(clk), .rst_n(rst_n), .we(wr_accept), .idx(wr_idx),
    .map(wr_map), .pass(wr_pass), .good(good));

  dmm_walker #(.NB(NB), .IW(IW)) u_walk (
    .clk(clk), .rst_n(rst_n), .start(start),
    .busy(busy), .done(done), .idx(walk_idx));

  dmm_classify #(.N(N), .NB(NB), .IW(IW)) u_cls (
    .good(good), .idx(walk_idx), .status(status_w), .cand(cand_w));

  assign st_we = busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NB; i++) status_q[i] <= ST_DEF;
      cand_q <= '0;
    end else if (st_we && int'(walk_idx) < NB) begin
      status_q[walk_idx] <= status_w;
      cand_q[walk_idx]   <= cand_w;
    end
  end

  always_comb begin
    if (int'(rd_idx) < NB) begin
      rd_status = status_q[rd_idx];
      rd_cand   = cand_q[rd_idx];
    end else begin
      rd_status = ST_DEF;
      rd_cand   = 1'b0;
    end
  end

  // R4: the unused code never reaches the result store
  a_r4_no_code11: assert property (@(posedge clk) disable iff (!rst_n)
    st_we |-> status_w != 2'b11);
  // R6: fully recovered blocks are never flagged
  a_r6_full_not_cand: assert property (@(posedge clk) disable iff (!rst_n)
    (st_we && status_w == ST_FULL) |-> !cand_w);
  // R8: maps stay frozen across a walk
  a_r8_maps_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(good));
  // R10: read results change only while walking
  a_r10_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(cand_q));
endmodule

// File: tb/test_defect_map_merge.sv
module test_defect_map_merge;
  localparam int N  = 4;
  localparam int NB = N * N;
  localparam int IW = $clog2(NB);

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, wr_pass = 0, start = 0;
  logic [IW-1:0] wr_idx = '0, rd_idx = '0;
  logic [1:0] wr_map = '0;
  logic busy, done, rd_cand;
  logic [1:0] rd_status;

  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  defect_map_merge #(.N(N)) i_defect_map_merge (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_map(wr_map),
    .wr_pass(wr_pass), .start(start), .busy(busy), .done(done),
    .rd_idx(rd_idx), .rd_status(rd_status), .rd_cand(rd_cand));

  // reference model
  bit seen [3][NB];
  bit bad  [3][NB];

  function automatic bit m_good(int m, int i);
    return seen[m][i] && !bad[m][i];
  endfunction
  function automatic int m_status(int i);
    int c = 0;
    for (int m = 0; m < 3; m++) if (m_good(m, i)) c++;
    return (c == 3) ? 2 : (c > 0 ? 1 : 0);
  endfunction
  function automatic bit m_cand(int i);
    int r = i / N, c = i % N;
    bit f = 0;
    if (m_status(i) == 2) return 0;
    for (int d = 0; d < 4; d++) begin
      int nr = r + ((d == 2) ? -1 : (d == 3) ? 1 : 0);
      int nc = c + ((d == 0) ? -1 : (d == 1) ? 1 : 0);
      if (nr >= 0 && nr < N && nc >= 0 && nc < N) begin
        int j = nr * N + nc;
        int s = m_status(j);
        if (s == 2) f = 1;
        if (s == 1 && ((d < 2) ? m_good(1, j) : m_good(2, j))) f = 1;
      end
    end
    return f;
  endfunction

  typedef struct { int idx; logic [1:0] st; logic c; string tag; } item_t;
  item_t q[$];

  task automatic note(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // monitor: pop expected items and compare with the read port
  initial forever begin
    @(negedge clk);
    if (q.size() > 0 && !busy) begin
      item_t it;
      it = q.pop_front();
      rd_idx = IW'(it.idx);
      #1;
      note(rd_status == it.st, it.tag, $sformatf("grade blk %0d", it.idx),
           int'(rd_status), int'(it.st));
      note(rd_cand == it.c, "R5 R6", $sformatf("cand blk %0d", it.idx),
           int'(rd_cand), int'(it.c));
    end
  end

  task automatic drain();
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wr(int i, int m, bit p);
    @(negedge clk);
    wr_en = 1; wr_idx = IW'(i); wr_map = 2'(m); wr_pass = p;
    @(negedge clk);
    wr_en = 0;
    if (m < 3) begin
      if (p) seen[m][i] = 1; else bad[m][i] = 1;
    end
  endtask

  // run a merge; optionally re-pulse start or inject a write mid-walk
  task automatic merge(string tag, bit restart, bit inject);
    int cnt = 0, nd = 0, k = 0;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    while (!done && k < 4 * NB) begin
      if (busy) cnt++;
      k++;
      start = restart && (k == 3);
      wr_en = inject && (k == 4);
      wr_idx = IW'(5); wr_map = 2'd1; wr_pass = 1'b0;
      @(negedge clk);
      start = 0; wr_en = 0;
    end
    if (done) nd++;
    @(negedge clk);
    if (done) nd++;
    note(cnt == NB, "R7", "busy cycles", cnt, NB);
    note(nd == 1, restart ? "R9" : "R7", "done pulses", nd, 1);
    for (int i = 0; i < NB; i++)
      q.push_back('{i, 2'(m_status(i)), m_cand(i), tag});
    drain();
  endtask

  int unsigned seed = 32'h1234_5678;
  function automatic int unsigned nxt();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed >> 8;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    note(busy == 0 && done == 0, "R1", "busy/done after reset", int'({busy, done}), 0);
    for (int i = 0; i < NB; i++) q.push_back('{i, 2'b00, 1'b0, "R1"});
    drain();

    // directed pattern
    for (int m = 0; m < 3; m++) wr(5, m, 1);       // full
    wr(6, 0, 1);                                   // partial via map 0 only
    wr(10, 0, 1); wr(10, 0, 0);                    // pass then fail: defective (R2)
    wr(0, 1, 1); wr(0, 2, 1); wr(0, 0, 0);         // partial
    wr(15, 2, 1);                                  // partial, good in map 2
    wr(3, 3, 1);                                   // ignored select (R2)
    merge("R2 R3 R4", 0, 0);

    // write during walk must be refused
    merge("R8", 0, 1);

    // write after merge not visible until next merge
    q.push_back('{5, 2'(m_status(5)), m_cand(5), "R10"});
    wr(5, 2, 0);
    drain();
    merge("R3 R4 R10", 1, 0);

    // scattered results
    for (int n = 0; n < 3; n++) begin
      for (int w = 0; w < 40; w++) begin
        int unsigned r = nxt();
        wr(int'(r % NB), int'((r >> 5) % 3), ((r >> 9) % 5) != 0);
      end
      merge("R3 R4", 0, 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule